// File: doc/BRIEF.md
# Dual-Mode Registered Bus Driver

This block carries a 12-bit data word from its input to two identical 12-bit output copies. A mode input picks one of two paths. In the first path the word moves through edge-triggered storage that loads on the rising clock edge. In the second path the input reaches the outputs combinationally, with no clock edge involved.

The storage is split into two groups. The upper four bits load on every rising edge. The lower eight bits load only when an active-low load-all input is asserted, and they hold their value otherwise. Storage keeps loading by these rules while the pass-through path is selected. Switching back to the registered path therefore shows the most recently captured word at once.

One active-low output enable gates both copies. Tri-state is modelled as a per-copy valid flag next to each data bus, so a high-impedance output appears as valid low with the data forced to zero. A synchronous active-high reset clears the storage.

Top module: `dual_mode_bus_driver`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all twelve stored bits become zero, and this takes priority over any load. With `bypass` low and `out_en_n` low after reset, both copies read 12'h000.
- R2: With `bypass` low (registered path) and `load_all_n` low, all of `din[11:0]` is stored at the rising edge. The outputs show the new word after that edge and do not change between edges when `din` changes.
- R3: With `load_all_n` high, only `din[11:8]` is stored at the rising edge, and stored bits [7:0] keep their previous value.
- R4: With `bypass` high (pass-through path), both output copies equal `din` combinationally, including changes of `din` between clock edges.
- R5: Storage loads by the R2/R3 rules while `bypass` is high. Lowering `bypass` shows the last stored word immediately, without waiting for a clock edge.
- R6: `copy0_data` and `copy1_data` always carry the same value, and `copy0_vld` and `copy1_vld` are always equal.
- R7: With `out_en_n` high, both valid flags are 0 and both data buses read 12'h000. With `out_en_n` low, both valid flags are 1. The output enable has no effect on stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bypass | input | 1 | 1 selects pass-through, 0 selects stored word |
| load_all_n | input | 1 | Active low: 0 loads all bits, 1 loads only bits [11:8] |
| out_en_n | input | 1 | Active-low output enable for both copies |
| din | input | 12 | Input data word |
| copy0_data | output | 12 | First output copy data |
| copy0_vld | output | 1 | First output copy driven (0 models high impedance) |
| copy1_data | output | 12 | Second output copy data |
| copy1_vld | output | 1 | Second output copy driven (0 models high impedance) |

## Verification
The hardest case to reach is the hidden update of the storage while the pass-through path hides it. The stored word cannot be seen until the mode flips back, and only a flip without a clock edge proves that no fresh load took place. The stimulus captures a word in pass-through mode. It then lowers `bypass` and changes `din` at a falling edge, and samples before the next rising edge. It also loads storage while the outputs are disabled and re-enables them with only the upper group loading. That shows the lower bits were captured out of sight.

// File: rtl/drv_pkg.sv
package drv_pkg;

    // Path selection encoding carried on the bypass input
    typedef enum logic {
        PATH_STORED = 1'b0,
        PATH_THRU   = 1'b1
    } path_mode_e;

    // Number of output copies the block drives
    localparam int unsigned NUM_COPIES = 2;

endpackage

// File: rtl/drv_split_reg.sv
module drv_split_reg #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned HI_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_all_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] stored
);

    localparam int unsigned LO_W = WIDTH - HI_W;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } split_t;

    split_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.hi = din[WIDTH-1:LO_W];
            if (!load_all_n) begin
                st_d.lo = din[LO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stored = st_q;

    // R1: reset wins over any load
    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (stored == '0));

    // R3: upper group follows din on every edge
    assert_hi_loads_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (stored[WIDTH-1:LO_W] == $past(din[WIDTH-1:LO_W])));

    // R3: lower group holds while load_all_n is high
    assert_lo_holds_R3: assert property (@(posedge clk) disable iff (rst)
        load_all_n |=> (stored[LO_W-1:0] == $past(stored[LO_W-1:0])));

    // R2: lower group loads while load_all_n is low
    assert_lo_loads_R2: assert property (@(posedge clk) disable iff (rst)
        !load_all_n |=> (stored[LO_W-1:0] == $past(din[LO_W-1:0])));

endmodule

// File: rtl/drv_path_sel.sv
module drv_path_sel #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             bypass,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] picked
);

    import drv_pkg::*;

    path_mode_e mode;

    always_comb begin
        mode   = path_mode_e'(bypass);
        picked = (mode == PATH_THRU) ? din : stored;
    end

endmodule

// File: rtl/drv_out_stage.sv
module drv_out_stage #(
    parameter int unsigned WIDTH  = 12,
    parameter int unsigned COPIES = 2
) (
    input  logic                         out_en_n,
    input  logic [WIDTH-1:0]             picked,
    output logic [COPIES-1:0][WIDTH-1:0] data,
    output logic [COPIES-1:0]            vld
);

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        always_comb begin
            vld[g]  = !out_en_n;
            data[g] = out_en_n ? '0 : picked;
        end
    end

endmodule

// File: rtl/dual_mode_bus_driver.sv
module dual_mode_bus_driver #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned HI_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass,
    input  logic             load_all_n,
    input  logic             out_en_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] copy0_data,
    output logic             copy0_vld,
    output logic [WIDTH-1:0] copy1_data,
    output logic             copy1_vld
);

    localparam int unsigned NCOPY = drv_pkg::NUM_COPIES;

    logic [WIDTH-1:0]            stored;
    logic [WIDTH-1:0]            picked;
    logic [NCOPY-1:0][WIDTH-1:0] out_data;
    logic [NCOPY-1:0]            out_vld;

    drv_split_reg #(.WIDTH(WIDTH), .HI_W(HI_W)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .load_all_n (load_all_n),
        .din        (din),
        .stored     (stored)
    );

    drv_path_sel #(.WIDTH(WIDTH)) u_sel (
        .bypass (bypass),
        .din    (din),
        .stored (stored),
        .picked (picked)
    );

    drv_out_stage #(.WIDTH(WIDTH), .COPIES(NCOPY)) u_out (
        .out_en_n (out_en_n),
        .picked   (picked),
        .data     (out_data),
        .vld      (out_vld)
    );

    assign copy0_data = out_data[0];
    assign copy0_vld  = out_vld[0];
    assign copy1_data = out_data[1];
    assign copy1_vld  = out_vld[1];

    // R6: both copies identical
    assert_copies_match_R6: assert property (@(posedge clk) disable iff (rst)
        (copy0_data == copy1_data) && (copy0_vld == copy1_vld));

    // R7: disabled outputs are released and read zero
    assert_released_R7: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (!copy0_vld && !copy1_vld && copy0_data == '0));

    // R7: enabled outputs are driven
    assert_driven_R7: assert property (@(posedge clk) disable iff (rst)
        !out_en_n |-> (copy0_vld && copy1_vld));

    // R4: pass-through follows din
    assert_thru_R4: assert property (@(posedge clk) disable iff (rst)
        (bypass && !out_en_n) |-> (copy0_data == din));

    // R2: registered path shows storage
    assert_stored_R2: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !out_en_n) |-> (copy0_data == stored));

endmodule

// File: tb/test_dual_mode_bus_driver.sv
`timescale 1ns/1ps
module test_dual_mode_bus_driver;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bypass = 1'b0;
    logic        load_all_n = 1'b0;
    logic        out_en_n = 1'b0;
    logic [11:0] din = '0;
    logic [11:0] copy0_data, copy1_data;
    logic        copy0_vld, copy1_vld;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_mode_bus_driver i_dual_mode_bus_driver (
        .clk        (clk),
        .rst        (rst),
        .bypass     (bypass),
        .load_all_n (load_all_n),
        .out_en_n   (out_en_n),
        .din        (din),
        .copy0_data (copy0_data),
        .copy0_vld  (copy0_vld),
        .copy1_data (copy1_data),
        .copy1_vld  (copy1_vld)
    );

    // Vector: [27] bypass [26] load_all_n [25] out_en_n [24] exp vld
    //         [23:12] din [11:0] expected data after the edge
    localparam int NVEC = 10;
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 12'hABC, 12'hABC}, // R2 full load
        {1'b0, 1'b1, 1'b0, 1'b1, 12'h123, 12'h1BC}, // R3 upper only
        {1'b0, 1'b1, 1'b0, 1'b1, 12'hFFF, 12'hFBC}, // R3 upper only
        {1'b0, 1'b0, 1'b0, 1'b1, 12'h5A5, 12'h5A5}, // R2 full load
        {1'b1, 1'b0, 1'b0, 1'b1, 12'h0F0, 12'h0F0}, // R4 pass-through
        {1'b1, 1'b1, 1'b0, 1'b1, 12'hE77, 12'hE77}, // R4 stores EF0
        {1'b0, 1'b1, 1'b0, 1'b1, 12'h3CC, 12'h3F0}, // R5 stores 3F0
        {1'b0, 1'b0, 1'b1, 1'b0, 12'h777, 12'h000}, // R7 off, stores 777
        {1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 12'h077}, // R7 on, stores 077
        {1'b1, 1'b0, 1'b1, 1'b0, 12'hAAA, 12'h000}  // R7 off in pass-through
    };

    task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [11:0] exp_d, input logic exp_v);
        chk({req, " copy0 data"}, copy0_data, exp_d);
        chk({req, " copy1 data R6"}, copy1_data, exp_d);
        chk({req, " copy0 vld"}, {11'd0, copy0_vld}, {11'd0, exp_v});
        chk({req, " copy1 vld R6"}, {11'd0, copy1_vld}, {11'd0, exp_v});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk_all("R1 reset state", 12'h000, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            bypass     = VEC[i][27];
            load_all_n = VEC[i][26];
            out_en_n   = VEC[i][25];
            din        = VEC[i][23:12];
            @(posedge clk);
            #1;
            chk_all($sformatf("vector %0d", i), VEC[i][11:0], VEC[i][24]);
        end
        // Storage now holds AAA (vector 9 loaded all bits)

        // R2: no change between edges in registered path
        @(negedge clk);
        bypass = 1'b0; load_all_n = 1'b0; out_en_n = 1'b0; din = 12'h321;
        #1;
        chk_all("R2 hold before edge", 12'hAAA, 1'b1);
        @(posedge clk); #1;
        chk_all("R2 load at edge", 12'h321, 1'b1);

        // R4: combinational follow mid-cycle
        @(negedge clk);
        bypass = 1'b1; din = 12'h456;
        #1;
        chk_all("R4 immediate", 12'h456, 1'b1);
        @(posedge clk); #1;          // storage takes 456
        din = 12'h9E1;
        #1;
        chk_all("R4 mid-cycle change", 12'h9E1, 1'b1);

        // R5: leave pass-through without an edge, storage shows 456
        @(negedge clk);
        bypass = 1'b0; din = 12'h789;
        #1;
        chk_all("R5 stored word visible", 12'h456, 1'b1);

        // R1: reset takes priority over a full load
        @(negedge clk);
        rst = 1'b1; din = 12'hFFF; load_all_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0; load_all_n = 1'b1; din = 12'h000;
        #1;
        chk_all("R1 reset clears", 12'h000, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule